// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block converts step-and-direction commands into the four winding enables of a unipolar stepper motor. All inputs are sampled by the system clock. A falling edge on the step strobe moves the motor one position along an eight-entry phase table. The direction input and the half/full-step select are taken at that edge.

In full-step mode only the two-phase table entries are used. In half-step mode each edge moves one entry, and the single-phase entries fall between the two-phase ones. After every phase change a boost enable is raised for a parameterised number of clock cycles. It stands in for the timer that selects the higher motor supply while the winding current is rising.

An inhibit input turns every output off. It does not lose the table position, so stepping resumes where it stopped.

Top module: `stp_sequencer`

## Requirements
- R1: The table position moves exactly once for each high-to-low transition of `step_in`, and the phase outputs show the new state within SYNC_STAGES+2 rising clock edges. Rising edges and steady levels never move it.
- R2: The position is a 3-bit index p, and outputs are written {a1,a2,b1,b2}. The table is p0=1010, p1=0010, p2=0110, p3=0100, p4=0101, p5=0001, p6=1001, p7=1000. No pair (a1/a2 or b1/b2) is ever both high. With `full_step_in` low, each edge moves p by one.
- R3: With `full_step_in` high, an edge that starts from an even p moves it by two, so only two-phase states are used.
- R4: With `dir_in` high, p increases modulo 8. With `dir_in` low, p decreases modulo 8.
- R5: `dir_in` and `full_step_in` matter only at a step edge. Changing them while `step_in` holds steady does not change the outputs.
- R6: A full-step edge taken from an odd (single-phase) p moves by one, to the neighbouring two-phase state in the selected direction.
- R7: While `inhibit_in` is high, all four phase outputs and `boost_out` are low, and step edges are ignored. On release, the outputs return to the state held before inhibit.
- R8: `boost_out` rises in the same cycle as a phase change. It stays high for exactly BOOST_CYCLES cycles and is never high while the phases are steady, unless its own count is still running.
- R9: A phase change during an active boost restarts the count, so the boost lasts from the first change until BOOST_CYCLES cycles after the last one.
- R10: Reset (synchronous, active high) loads every input synchronizer with logic high, so the block starts inhibited, with p=0 and `boost_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step strobe; a falling edge moves one step |
| dir_in | input | 1 | 1 = forward, 0 = reverse through the table |
| full_step_in | input | 1 | 1 = full steps, 0 = half steps |
| inhibit_in | input | 1 | 1 = all outputs off, stepping frozen |
| ph_a1 | output | 1 | Winding A, first half |
| ph_a2 | output | 1 | Winding A, second half |
| ph_b1 | output | 1 | Winding B, first half |
| ph_b2 | output | 1 | Winding B, second half |
| boost_out | output | 1 | High-supply enable after each phase change |

## Verification
Random pulse trains mix direction and mode on every edge. Comparing the outputs against a table model after each falling edge separates a wrong step size or direction from a missing or doubled step, and a check after each rising edge catches movement on the wrong edge. Directed runs do three things: they toggle direction and mode between edges to show the values are only taken at the edge; they enter full-step mode from a single-phase state to exercise the odd-position rule; and they pulse the strobe while inhibited to show the position is frozen and then restored. Boost pulses are measured cycle by cycle, both for a lone step and for two closely spaced steps, which separates a retriggered count from one that runs on or is ignored.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef logic [2:0] stp_pos_t;

  typedef struct packed {
    logic a1;
    logic a2;
    logic b1;
    logic b2;
  } stp_phase_t;

  // Even positions energise both windings, odd positions one winding.
  function automatic stp_phase_t stp_decode(input stp_pos_t p);
    stp_phase_t r;
    case (p)
      3'd0: r = 4'b1010;
      3'd1: r = 4'b0010;
      3'd2: r = 4'b0110;
      3'd3: r = 4'b0100;
      3'd4: r = 4'b0101;
      3'd5: r = 4'b0001;
      3'd6: r = 4'b1001;
      default: r = 4'b1000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stp_phase_seq.sv
module stp_phase_seq
  import stp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     advance,
  input  logic     fwd,
  input  logic     full,
  output stp_pos_t pos
);
  stp_pos_t stride;
  stp_pos_t nxt;

  always_comb begin
    // Full steps from a single-phase state only reach the next two-phase state.
    stride = (full && !pos[0]) ? 3'd2 : 3'd1;
    nxt    = fwd ? pos + stride : pos - stride;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (advance) pos <= nxt;
  end
endmodule

// File: rtl/stp_boost_timer.sv
module stp_boost_timer #(
  parameter int CYCLES = 16,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic          active
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (load) cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
  import stp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BOOST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  input  logic dir_in,
  input  logic full_step_in,
  input  logic inhibit_in,
  output logic ph_a1,
  output logic ph_a2,
  output logic ph_b1,
  output logic ph_b2,
  output logic boost_out
);
  localparam int IN_W = 4;
  localparam int BOOST_W = $clog2(BOOST_CYCLES + 1);

  logic [IN_W-1:0] raw_in, sync_q;
  logic step_s, dir_s, full_s, inh_s;
  logic step_prev, fire;
  stp_pos_t pos;
  logic [BOOST_W-1:0] boost_cnt;
  logic boost_act;
  stp_phase_t ph_q;
  logic boost_q;

  assign raw_in = {step_in, dir_in, full_step_in, inhibit_in};

  stp_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
  );

  assign {step_s, dir_s, full_s, inh_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) step_prev <= 1'b1;
    else step_prev <= step_s;
  end

  assign fire = step_prev && !step_s && !inh_s;

  stp_phase_seq u_seq (
    .clk(clk), .rst(rst), .advance(fire), .fwd(dir_s), .full(full_s), .pos(pos)
  );

  stp_boost_timer #(.CYCLES(BOOST_CYCLES)) u_boost (
    .clk(clk), .rst(rst), .clear(inh_s), .load(fire),
    .cnt(boost_cnt), .active(boost_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      boost_q <= 1'b0;
    end else begin
      ph_q    <= inh_s ? '0 : stp_decode(pos);
      boost_q <= boost_act && !inh_s;
    end
  end

  assign ph_a1 = ph_q.a1;
  assign ph_a2 = ph_q.a2;
  assign ph_b1 = ph_q.b1;
  assign ph_b2 = ph_q.b2;
  assign boost_out = boost_q;
endmodule

// File: rtl/stp_sequencer_chk.sv
module stp_sequencer_chk #(
  parameter int BOOST_CYCLES = 16,
  localparam int CW = $clog2(BOOST_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fire,
  input logic          dir_s,
  input logic          full_s,
  input logic          inh_s,
  input logic [2:0]    pos,
  input logic [CW-1:0] cnt,
  input logic [3:0]    ph,
  input logic          boost
);
  assert_no_move_without_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pos));

  assert_half_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !full_s && dir_s) |=> (pos == $past(pos) + 3'd1));

  assert_pairs_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(ph[3] && ph[2]) && !(ph[1] && ph[0]));

  assert_full_lands_even_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && full_s) |=> !pos[0]);

  assert_half_reverse_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && !full_s && !dir_s) |=> (pos == $past(pos) - 3'd1));

  assert_inhibit_off_R7: assert property (@(posedge clk) disable iff (rst)
    inh_s |=> (ph == 4'b0000 && !boost));

  assert_boost_on_change_R8: assert property (@(posedge clk) disable iff (rst)
    (ph != $past(ph) && ph != 4'b0000 && $past(ph) != 4'b0000) |-> boost);

  assert_boost_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(BOOST_CYCLES));
endmodule

bind stp_sequencer stp_sequencer_chk #(.BOOST_CYCLES(BOOST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .fire(fire), .dir_s(dir_s), .full_s(full_s),
  .inh_s(inh_s), .pos(pos), .cnt(boost_cnt),
  .ph({ph_a1, ph_a2, ph_b1, ph_b2}), .boost(boost_out)
);

// File: tb/sim_stp_sequencer.sv
module sim_stp_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int BOOST = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_in = 1'b1, dir_in = 1'b1, full_step_in = 1'b1, inhibit_in = 1'b1;
  logic ph_a1, ph_a2, ph_b1, ph_b2, boost_out;

  int checks = 0;
  int fails = 0;
  int mpos = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stp_sequencer #(.SYNC_STAGES(2), .BOOST_CYCLES(BOOST)) u0 (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
    .full_step_in(full_step_in), .inhibit_in(inhibit_in),
    .ph_a1(ph_a1), .ph_a2(ph_a2), .ph_b1(ph_b1), .ph_b2(ph_b2),
    .boost_out(boost_out)
  );

  function automatic logic [3:0] exp_phase(input int p);
    logic a1, a2, b1, b2;
    a1 = (p == 6 || p == 7 || p == 0);
    a2 = (p >= 2 && p <= 4);
    b1 = (p <= 2);
    b2 = (p >= 4 && p <= 6);
    return {a1, a2, b1, b2};
  endfunction

  function automatic int next_pos(input int p, input bit fwd, input bit full);
    int s;
    s = (full && (p % 2 == 0)) ? 2 : 1;
    return fwd ? (p + s) % 8 : (p + 8 - s) % 8;
  endfunction

  function automatic logic [3:0] phases();
    return {ph_a1, ph_a2, ph_b1, ph_b2};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One strobe with the model updated; checks after both edges.
  task automatic pulse(input bit d, input bit f, input string req);
    dir_in = d;
    full_step_in = f;
    cycles(3);
    step_in = 1'b0;
    if (!inhibit_in) mpos = next_pos(mpos, d, f);
    cycles(8);
    check({req, " after falling edge"}, phases(), inhibit_in ? 0 : exp_phase(mpos));
    step_in = 1'b1;
    cycles(6);
    check("R1 rising edge no move", phases(), inhibit_in ? 0 : exp_phase(mpos));
  endtask

  // Counts boost-high cycles and checks boost rises with a phase change.
  task automatic measure_boost(input int gap, input int expect_len);
    int hi;
    logic [3:0] prev;
    logic prev_b;
    hi = 0;
    prev = phases();
    prev_b = boost_out;
    step_in = 1'b0;
    mpos = next_pos(mpos, dir_in, full_step_in);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (i == 3) step_in = 1'b1;
      if (gap > 0 && i == gap - 1) begin
        step_in = 1'b0;
        mpos = next_pos(mpos, dir_in, full_step_in);
      end
      if (gap > 0 && i == gap + 3) step_in = 1'b1;
      if (boost_out && !prev_b)
        check("R8 boost rises with phase change", int'(phases() != prev), 1);
      if (boost_out) hi++;
      prev = phases();
      prev_b = boost_out;
    end
    check(gap > 0 ? "R9 retriggered boost length" : "R8 boost length", hi, expect_len);
    check("R8 phase after boost run", phases(), exp_phase(mpos));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51E9));
    cycles(4);
    rst = 1'b0;
    cycles(6);
    check("R10 reset phases off", phases(), 0);
    check("R10 reset boost low", boost_out, 0);

    inhibit_in = 1'b0;
    cycles(6);
    check("R10 start position p0", phases(), exp_phase(0));
    check("R8 no boost without phase change", boost_out, 0);

    // Half steps forward then reverse
    pulse(1'b1, 1'b0, "R2 half forward");
    pulse(1'b1, 1'b0, "R2 half forward");
    pulse(1'b0, 1'b0, "R4 half reverse");
    // Full steps both ways from an odd position and from even
    pulse(1'b1, 1'b1, "R6 full from odd forward");
    pulse(1'b1, 1'b1, "R3 full forward");
    pulse(1'b0, 0, "R4 half reverse to odd");
    pulse(1'b0, 1'b1, "R6 full from odd reverse");
    pulse(1'b0, 1'b1, "R3 full reverse wrap");

    // R5: toggling dir and mode between edges does nothing
    for (int i = 0; i < 6; i++) begin
      dir_in = ~dir_in;
      full_step_in = i[0];
      cycles(3);
    end
    cycles(6);
    check("R5 dir/mode change between edges", phases(), exp_phase(mpos));

    // R5: value at the edge counts, changes while low do not
    dir_in = 1'b0; full_step_in = 1'b0;
    cycles(3);
    step_in = 1'b0;
    mpos = next_pos(mpos, 1'b0, 1'b0);
    cycles(1);
    dir_in = 1'b1; full_step_in = 1'b1;
    cycles(8);
    check("R5 sampled at falling edge", phases(), exp_phase(mpos));
    step_in = 1'b1;
    cycles(6);

    // R7: inhibit, strobe while inhibited, release
    inhibit_in = 1'b1;
    cycles(6);
    check("R7 inhibit phases off", phases(), 0);
    check("R7 inhibit boost off", boost_out, 0);
    pulse(1'b1, 1'b1, "R7 step ignored while inhibited");
    pulse(1'b0, 1'b0, "R7 step ignored while inhibited");
    inhibit_in = 1'b0;
    cycles(6);
    check("R7 position kept after release", phases(), exp_phase(mpos));
    check("R7 no boost on release", boost_out, 0);

    // R8 and R9: boost timing
    cycles(BOOST + 4);
    dir_in = 1'b1; full_step_in = 1'b0;
    cycles(3);
    measure_boost(0, BOOST);
    cycles(5);
    measure_boost(6, 6 + BOOST);

    // Random trains
    for (int n = 0; n < 200; n++) begin
      bit d, f;
      d = 1'($urandom);
      f = 1'($urandom);
      pulse(d, f, f ? "R3 random full step" : "R2 random half step");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule